// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits on the host write path of a parallel NOR-style flash model and turns runs of bus writes into operations. It follows the usual two-write unlock handshake, recognises word program, whole-array erase, entry into and exit from a persistent fast-program mode, and a reset code. When a sequence completes it raises a one-cycle start pulse carrying an operation code, the target address and the data word, meant for a separate program/erase engine.

While the engine reports busy, every host write is dropped without any effect. While the engine reports an error, only the reset code is honoured; it raises a one-cycle clear pulse back to the engine. In fast-program mode a program needs only two writes. The reset code does not leave that mode; only a dedicated two-write exit sequence does.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After synchronous reset, `start_valid`, `err_clear` and `bypass_active` are all 0.
- R2: In normal mode, the writes 0xAA@0x555, 0x55@0x2AA, 0xA0@0x555 and then any address/data produce `start_valid`=1 in the cycle after the fourth write, with `start_op`=2'b01 (program) and the fourth write's address and data on `start_addr`/`start_data`. Unlock addresses are compared on the low 11 address bits, command codes on the low 8 data bits.
- R3: The six writes 0xAA@0x555, 0x55@0x2AA, 0x80@0x555, 0xAA@0x555, 0x55@0x2AA, 0x10@0x555 produce `start_valid`=1 with `start_op`=2'b10 (erase) after the sixth write and never after the first five.
- R4: The writes 0xAA@0x555, 0x55@0x2AA, 0x20@0x555 set `bypass_active` to 1.
- R5: In fast-program mode, 0xA0 at any address followed by any address/data write produces a program start (`start_op`=2'b01) carrying the second write's address and data, and the block stays in fast-program mode.
- R6: In fast-program mode, 0x90 followed by 0x00 (any addresses) clears `bypass_active`; 0x90 followed by another value leaves it set.
- R7: A write of 0xF0 outside a data-capture step raises `err_clear` for one cycle; in fast-program mode `bypass_active` stays 1.
- R8: A write that does not match the next step of a sequence returns the decoder to the idle step of its current mode, so the remaining writes of that sequence start nothing.
- R9: While `ctl_busy` is 1, every write is ignored, including 0xB0 and 0xF0: no start, no clear, no change of mode or sequence step.
- R10: While `ctl_error` is 1, every write other than 0xF0 is ignored; 0xF0 raises `err_clear`.
- R11: `start_valid` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe, one cycle per write |
| wr_addr | input | AW | Host write address |
| wr_data | input | DW | Host write data |
| ctl_busy | input | 1 | Program/erase engine is running |
| ctl_error | input | 1 | Program/erase engine holds an error |
| start_valid | output | 1 | One-cycle operation start request |
| start_op | output | 2 | 01 program, 10 erase |
| start_addr | output | AW | Address captured for the operation |
| start_data | output | DW | Data captured for the operation |
| err_clear | output | 1 | One-cycle error-clear request |
| bypass_active | output | 1 | Fast-program mode is active |

## Verification
Complete sequences in both modes are driven with distinct addresses and data so a start that latches the wrong write is told apart from a correct one. Broken sequences (wrong address in the unlock, wrong code after 0x90, stray codes in fast mode) separate a return to idle of the current mode from a fall back to normal mode. Writes issued while the engine is busy or in error are followed, after release, by the remainder of a sequence, which distinguishes a write that was truly dropped from one that advanced the step counter.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_U1, S_U2, S_PGM, S_E1, S_E2, S_E3, S_BIDLE, S_BPGM, S_BEXIT
  } fcd_state_e;

  localparam logic [1:0] OP_NONE  = 2'b00;
  localparam logic [1:0] OP_PROG  = 2'b01;
  localparam logic [1:0] OP_ERASE = 2'b10;

  typedef struct packed {
    logic at555;
    logic at2aa;
    logic aa;
    logic x55;
    logic a0;
    logic x80;
    logic x20;
    logic x10;
    logic x90;
    logic x00;
    logic f0;
  } fcd_hit_t;
endpackage

// File: rtl/fcd_match.sv
module fcd_match #(
  parameter int CAW = 11
) (
  input  logic [CAW-1:0] addr_lo,
  input  logic [7:0]     code,
  output fcd_pkg::fcd_hit_t hit
);
  always_comb begin
    hit.at555 = (addr_lo == CAW'(11'h555));
    hit.at2aa = (addr_lo == CAW'(11'h2AA));
    hit.aa    = (code == 8'hAA);
    hit.x55   = (code == 8'h55);
    hit.a0    = (code == 8'hA0);
    hit.x80   = (code == 8'h80);
    hit.x20   = (code == 8'h20);
    hit.x10   = (code == 8'h10);
    hit.x90   = (code == 8'h90);
    hit.x00   = (code == 8'h00);
    hit.f0    = (code == 8'hF0);
  end
endmodule

// File: rtl/fcd_seq.sv
module fcd_seq (
  input  logic clk,
  input  logic rst,
  input  logic wr_en,
  input  logic busy,
  input  logic err,
  input  fcd_pkg::fcd_hit_t hit,
  output fcd_pkg::fcd_state_e st,
  output logic fire_prog,
  output logic fire_erase,
  output logic fire_clr
);
  import fcd_pkg::*;

  fcd_state_e nxt;
  logic in_byp, take;

  assign in_byp = (st == S_BIDLE) || (st == S_BPGM) || (st == S_BEXIT);
  assign take   = wr_en && !busy;

  always_comb begin
    nxt        = st;
    fire_prog  = 1'b0;
    fire_erase = 1'b0;
    fire_clr   = 1'b0;
    if (take && err) begin
      if (hit.f0) begin
        fire_clr = 1'b1;
        nxt      = in_byp ? S_BIDLE : S_IDLE;
      end
    end else if (take) begin
      fire_clr = hit.f0 && (st != S_PGM) && (st != S_BPGM);
      case (st)
        S_IDLE:  nxt = (hit.aa  && hit.at555) ? S_U1 : S_IDLE;
        S_U1:    nxt = (hit.x55 && hit.at2aa) ? S_U2 : S_IDLE;
        S_U2: begin
          if (hit.at555 && hit.a0)       nxt = S_PGM;
          else if (hit.at555 && hit.x80) nxt = S_E1;
          else if (hit.at555 && hit.x20) nxt = S_BIDLE;
          else                           nxt = S_IDLE;
        end
        S_PGM: begin
          fire_prog = 1'b1;
          nxt       = S_IDLE;
        end
        S_E1:    nxt = (hit.aa  && hit.at555) ? S_E2 : S_IDLE;
        S_E2:    nxt = (hit.x55 && hit.at2aa) ? S_E3 : S_IDLE;
        S_E3: begin
          fire_erase = hit.x10 && hit.at555;
          nxt        = S_IDLE;
        end
        S_BIDLE: begin
          if (hit.a0)       nxt = S_BPGM;
          else if (hit.x90) nxt = S_BEXIT;
          else              nxt = S_BIDLE;
        end
        S_BPGM: begin
          fire_prog = 1'b1;
          nxt       = S_BIDLE;
        end
        S_BEXIT: nxt = hit.x00 ? S_IDLE : S_BIDLE;
        default: nxt = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st <= S_IDLE;
    else     st <= nxt;
  end

  assert_busy_hold_R9: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(st));
  assert_bypass_keep_R7: assert property (@(posedge clk) disable iff (rst)
    (st == S_BIDLE && wr_en && !busy && hit.f0) |=> (st == S_BIDLE));
  assert_bypass_exit_R6: assert property (@(posedge clk) disable iff (rst)
    (st == S_BEXIT && wr_en && !busy && !err && hit.x00) |=> (st == S_IDLE));
  assert_error_gate_R10: assert property (@(posedge clk) disable iff (rst)
    (err && !hit.f0) |=> $stable(st));
endmodule

// File: rtl/fcd_out.sv
module fcd_out #(
  parameter int AW = 21,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fire_prog,
  input  logic          fire_erase,
  input  logic          fire_clr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data,
  output logic          start_valid,
  output logic [1:0]    start_op,
  output logic [AW-1:0] start_addr,
  output logic [DW-1:0] start_data,
  output logic          err_clear
);
  import fcd_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      start_valid <= 1'b0;
      start_op    <= OP_NONE;
      start_addr  <= '0;
      start_data  <= '0;
      err_clear   <= 1'b0;
    end else begin
      start_valid <= fire_prog || fire_erase;
      err_clear   <= fire_clr;
      if (fire_prog || fire_erase) begin
        start_op   <= fire_erase ? OP_ERASE : OP_PROG;
        start_addr <= addr;
        start_data <= data;
      end
    end
  end

  assert_start_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    start_valid |=> !start_valid);
  assert_start_op_R2: assert property (@(posedge clk) disable iff (rst)
    start_valid |-> (start_op == OP_PROG || start_op == OP_ERASE));
  assert_clear_excl_R7: assert property (@(posedge clk) disable iff (rst)
    err_clear |-> !start_valid);
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
  parameter int AW  = 21,
  parameter int DW  = 16,
  parameter int CAW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          ctl_busy,
  input  logic          ctl_error,
  output logic          start_valid,
  output logic [1:0]    start_op,
  output logic [AW-1:0] start_addr,
  output logic [DW-1:0] start_data,
  output logic          err_clear,
  output logic          bypass_active
);
  import fcd_pkg::*;

  fcd_hit_t   hit;
  fcd_state_e st;
  logic       fire_prog, fire_erase, fire_clr;

  fcd_match #(.CAW(CAW)) match_i (
    .addr_lo (wr_addr[CAW-1:0]),
    .code    (wr_data[7:0]),
    .hit     (hit)
  );

  fcd_seq seq_i (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .busy       (ctl_busy),
    .err        (ctl_error),
    .hit        (hit),
    .st         (st),
    .fire_prog  (fire_prog),
    .fire_erase (fire_erase),
    .fire_clr   (fire_clr)
  );

  fcd_out #(.AW(AW), .DW(DW)) out_i (
    .clk         (clk),
    .rst         (rst),
    .fire_prog   (fire_prog),
    .fire_erase  (fire_erase),
    .fire_clr    (fire_clr),
    .addr        (wr_addr),
    .data        (wr_data),
    .start_valid (start_valid),
    .start_op    (start_op),
    .start_addr  (start_addr),
    .start_data  (start_data),
    .err_clear   (err_clear)
  );

  assign bypass_active = (st == S_BIDLE) || (st == S_BPGM) || (st == S_BEXIT);
endmodule

// File: tb/flash_cmd_decoder_tb.sv
`timescale 1ns/1ps
module flash_cmd_decoder_tb_top;
  localparam int AW = 21;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic          ctl_busy = 1'b0;
  logic          ctl_error = 1'b0;
  logic          start_valid, err_clear, bypass_active;
  logic [1:0]    start_op;
  logic [AW-1:0] start_addr;
  logic [DW-1:0] start_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  flash_cmd_decoder #(.AW(AW), .DW(DW)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ctl_busy(ctl_busy), .ctl_error(ctl_error), .start_valid(start_valid),
    .start_op(start_op), .start_addr(start_addr), .start_data(start_data),
    .err_clear(err_clear), .bypass_active(bypass_active)
  );

  task automatic check(input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // one write cycle; outputs are sampled at the negedge after the capturing edge
  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic unlock();
    wr(21'h555, 16'h00AA);
    wr(21'h2AA, 16'h0055);
  endtask

  task automatic t_reset();
    check("R1", "start_valid", start_valid, 0);
    check("R1", "err_clear", err_clear, 0);
    check("R1", "bypass_active", bypass_active, 0);
  endtask

  task automatic t_normal_prog();
    unlock();
    wr(21'h555, 16'h00A0);
    check("R2", "no start before data", start_valid, 0);
    wr(21'h1234A, 16'hBEEF);
    check("R2", "start", start_valid, 1);
    check("R2", "op", start_op, 1);
    check("R2", "addr", start_addr, 21'h1234A);
    check("R2", "data", start_data, 16'hBEEF);
    @(negedge clk);
    check("R11", "single pulse", start_valid, 0);
  endtask

  task automatic t_erase_busy();
    unlock();
    wr(21'h555, 16'h0080);
    unlock();
    check("R3", "no start after five", start_valid, 0);
    wr(21'h555, 16'h0010);
    check("R3", "start", start_valid, 1);
    check("R3", "op", start_op, 2);
    ctl_busy = 1'b1;
    wr(21'h00777, 16'h00B0);
    check("R9", "suspend ignored", start_valid, 0);
    wr(21'h00777, 16'h00F0);
    check("R9", "reset ignored", err_clear, 0);
    unlock();
    wr(21'h555, 16'h00A0);
    ctl_busy = 1'b0;
    wr(21'h00100, 16'h1111);
    check("R9", "busy writes did not advance", start_valid, 0);
  endtask

  task automatic t_mismatch();
    wr(21'h555, 16'h00AA);
    wr(21'h123, 16'h0055);
    wr(21'h555, 16'h00A0);
    wr(21'h00200, 16'h2222);
    check("R8", "broken unlock starts nothing", start_valid, 0);
  endtask

  task automatic t_bypass();
    unlock();
    wr(21'h555, 16'h0020);
    check("R4", "bypass entered", bypass_active, 1);
    wr(21'h07777, 16'h00A0);
    wr(21'h00042, 16'h1357);
    check("R5", "start", start_valid, 1);
    check("R5", "op", start_op, 1);
    check("R5", "addr", start_addr, 21'h00042);
    check("R5", "data", start_data, 16'h1357);
    check("R5", "still bypass", bypass_active, 1);
    ctl_busy = 1'b1;
    wr(21'h0, 16'h0090);
    wr(21'h0, 16'h0000);
    ctl_busy = 1'b0;
    check("R9", "exit ignored while busy", bypass_active, 1);
    wr(21'h0, 16'h00F0);
    check("R7", "clear pulse", err_clear, 1);
    check("R7", "bypass kept", bypass_active, 1);
    wr(21'h0, 16'h0055);
    check("R8", "stray code keeps bypass", bypass_active, 1);
    wr(21'h0, 16'h00A0);
    wr(21'h00300, 16'h3333);
    check("R8", "bypass idle accepts program", start_valid, 1);
  endtask

  task automatic t_error();
    ctl_error = 1'b1;
    wr(21'h0, 16'h00A0);
    wr(21'h00400, 16'h4444);
    check("R10", "writes dropped in error", start_valid, 0);
    wr(21'h0, 16'h00F0);
    check("R10", "clear in error", err_clear, 1);
    ctl_error = 1'b0;
    check("R10", "bypass kept", bypass_active, 1);
    wr(21'h0, 16'h0000);
    check("R10", "A0 was dropped", start_valid, 0);
  endtask

  task automatic t_exit();
    wr(21'h0, 16'h0090);
    wr(21'h0, 16'h0012);
    check("R6", "wrong second code keeps bypass", bypass_active, 1);
    wr(21'h0, 16'h0090);
    wr(21'h0, 16'h0000);
    check("R6", "exit", bypass_active, 0);
    wr(21'h0, 16'h00A0);
    wr(21'h00500, 16'h5555);
    check("R6", "two-write program gone", start_valid, 0);
    wr(21'h0, 16'h00F0);
    check("R7", "clear in normal mode", err_clear, 1);
    check("R7", "normal mode kept", bypass_active, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_normal_prog();
    t_erase_busy();
    t_mismatch();
    t_bypass();
    t_error();
    t_exit();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule